// File: doc/BRIEF.md
# Capability tag keeper for a small data memory

This block stands between a core's load/store port and a small data RAM. For every capability-sized, capability-aligned word of that RAM it holds one hidden validity bit. That bit records whether the word holds a genuine capability. Only a capability store can set it. Any ordinary write that lands on the word clears it, in the same cycle as the data write, so a word can never hold a mix of new bytes and a set tag.

Each request carries two page-level permission inputs. One lets capability loads keep their tag; the other allows tagged capability stores. A forbidden capability load is not an error: it returns the data with the tag forced low. A forbidden tagged store is refused with a fault. The response comes one cycle after the request and carries the read word, its tag, a fault flag, a fault code and the faulting byte address.

Top module: `tag_mem_ctrl`

## Requirements
- R1: A data load (op 00) returns the addressed word, and rsp_rtag is always 0, so a data load never exposes the tag.
- R2: An aligned capability store (op 11) with req_wtag=1 and req_pg_st_cap=1 writes all bytes of the word and sets its tag. A later aligned capability load (op 10) with req_pg_ld_cap=1 returns that word with rsp_rtag=1.
- R3: A data store (op 01) writes only the bytes whose req_wmask bit is set. If any mask bit is set, it clears the word's tag in the same cycle. A store with an all-zero mask changes neither data nor tag.
- R4: Tags are indexed by word address (req_addr bits above the byte offset), so every byte address inside a word reaches the same tag.
- R5: A capability load or store whose address has a nonzero byte offset (low 4 bits for a 128-bit word) faults with code 0x0A. It returns zero data and tag 0 and leaves memory and tags unchanged.
- R6: A capability load with req_pg_ld_cap=0 returns the word with rsp_rtag=0 and no fault.
- R7: A tagged capability store with req_pg_st_cap=0 faults with code 0x09 and changes neither data nor tag.
- R8: An untagged capability store (req_wtag=0) writes the word and clears its tag, even when req_pg_st_cap=0.
- R9: After reset all tags are 0, all words read as zero, and rsp_valid is low.
- R10: req_ready is always high, and rsp_valid is high exactly one cycle after req_valid. On a fault, rsp_faddr equals the request address. Without a fault, rsp_fault, rsp_fcode and rsp_faddr are zero. Stores return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_op | input | 2 | 00 data load, 01 data store, 10 cap load, 11 cap store |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_wmask | input | DATA_W/8 | Byte enables for data stores |
| req_wtag | input | 1 | Tag of the stored capability |
| req_pg_ld_cap | input | 1 | Page allows capability loads |
| req_pg_st_cap | input | 1 | Page allows tagged capability stores |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Load data |
| rsp_rtag | output | 1 | Tag of the loaded word |
| rsp_fault | output | 1 | Request faulted |
| rsp_fcode | output | 8 | Fault code (0x09 permission, 0x0A misaligned) |
| rsp_faddr | output | ADDR_W | Faulting byte address |

## Verification
The bench builds the block with its defaults: 128-bit words and 1 KiB, which gives 64 tagged words and a 10-bit address. With these values the last word (0x3F0) and its top byte (0x3FF) are easy to reach, so one test can check that a byte write at the far end of a word clears that word's tag. The 16-byte word also lets single-byte masks show that a partial write keeps the other bytes and still clears the tag.

// File: rtl/tag_mem_ctrl.sv
module tag_mem_ctrl #(
  parameter int DATA_W    = 128,
  parameter int MEM_BYTES = 1024,
  parameter int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_wmask,
  input  logic                req_wtag,
  input  logic                req_pg_ld_cap,
  input  logic                req_pg_st_cap,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_rtag,
  output logic                rsp_fault,
  output logic [7:0]          rsp_fcode,
  output logic [ADDR_W-1:0]   rsp_faddr
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFS_W = $clog2(BYTES);
  localparam int WORDS = MEM_BYTES / BYTES;
  localparam int IDX_W = ADDR_W - OFS_W;
  localparam logic [7:0] FC_PERM  = 8'h09;
  localparam logic [7:0] FC_ALIGN = 8'h0A;

  logic [DATA_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  tags;
  logic [DATA_W-1:0] merged;

  wire [IDX_W-1:0] idx    = req_addr[ADDR_W-1:OFS_W];
  wire             is_cap = req_op[1];
  wire             is_st  = req_op[0];
  wire             misal  = |req_addr[OFS_W-1:0];
  wire             f_algn = req_valid & is_cap & misal;
  wire             f_perm = req_valid & is_cap & is_st & ~misal & req_wtag & ~req_pg_st_cap;
  wire             fault  = f_algn | f_perm;
  wire             cap_wr = req_valid & is_cap & is_st & ~fault;
  wire             dat_wr = req_valid & ~is_cap & is_st;
  wire             rd_ok  = req_valid & ~is_st & ~fault;

  assign req_ready = 1'b1;

  for (genvar b = 0; b < BYTES; b++) begin : g_merge
    assign merged[b*8 +: 8] = req_wmask[b] ? req_wdata[b*8 +: 8] : mem[idx][b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      tags      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_rtag  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_fcode <= '0;
      rsp_faddr <= '0;
    end else begin
      if (cap_wr) begin
        mem[idx]  <= req_wdata;
        tags[idx] <= req_wtag;
      end
      if (dat_wr) begin
        mem[idx] <= merged;
        if (|req_wmask) tags[idx] <= 1'b0;
      end
      rsp_valid <= req_valid;
      rsp_rdata <= rd_ok ? mem[idx] : '0;
      rsp_rtag  <= rd_ok & is_cap & req_pg_ld_cap & tags[idx];
      rsp_fault <= fault;
      rsp_fcode <= f_algn ? FC_ALIGN : (f_perm ? FC_PERM : 8'h00);
      rsp_faddr <= fault ? req_addr : '0;
    end
  end

  // R3
  dstore_clears_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b01 && |req_wmask) |=> (tags[$past(idx)] == 1'b0));

  // R7
  perm_fault_keeps_tag_chk: assert property (@(posedge clk) disable iff (rst)
    f_perm |=> (tags[$past(idx)] == $past(tags[idx])) && rsp_fcode == FC_PERM);

  // R5
  misaligned_keeps_word_chk: assert property (@(posedge clk) disable iff (rst)
    f_algn |=> (mem[$past(idx)] == $past(mem[idx])) && rsp_fault && !rsp_rtag);

  // R6
  ld_strip_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b10 && !misal && !req_pg_ld_cap) |=> (!rsp_rtag && !rsp_fault));

  // R1
  dload_no_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'b00) |=> !rsp_rtag);

  // R10
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));
endmodule

// File: tb/tb_tag_mem_ctrl.sv
module tb_tag_mem_ctrl;
  localparam int DW = 128, MB = 1024, AW = 10, BY = 16, NW = 64;

  logic clk = 1'b0, rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BY-1:0] req_wmask = '0;
  logic req_wtag = 1'b0, req_pg_ld_cap = 1'b1, req_pg_st_cap = 1'b1;
  logic rsp_valid, rsp_rtag, rsp_fault;
  logic [DW-1:0] rsp_rdata;
  logic [7:0]    rsp_fcode;
  logic [AW-1:0] rsp_faddr;

  tag_mem_ctrl #(.DATA_W(DW), .MEM_BYTES(MB), .ADDR_W(AW)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] mm [NW];
  logic [NW-1:0] mt;

  typedef struct packed {
    logic [1:0] op; logic [9:0] addr; logic [31:0] seed; logic [15:0] mask;
    logic wtag; logic pgl; logic pgs; logic ef; logic [7:0] ec; logic et;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t V [NV] = '{
    '{2'b11, 10'h040, 32'hA5A50001, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b10, 10'h040, 32'h0,        16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1},
    '{2'b00, 10'h04C, 32'h0,        16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b10, 10'h040, 32'h0,        16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b01, 10'h044, 32'h11223344, 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b10, 10'h040, 32'h0,        16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b11, 10'h080, 32'hDEAD0007, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 8'h09, 1'b0},
    '{2'b10, 10'h080, 32'h0,        16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b11, 10'h080, 32'h0BEE0009, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},
    '{2'b10, 10'h080, 32'h0,        16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b11, 10'h0C8, 32'hFACE000B, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0A, 1'b0},
    '{2'b10, 10'h0C4, 32'h0,        16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 8'h0A, 1'b0},
    '{2'b11, 10'h3F0, 32'h7777000D, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b01, 10'h3F0, 32'h9999000E, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b10, 10'h3F0, 32'h0,        16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1},
    '{2'b01, 10'h3FF, 32'hC3C3C3C3, 16'h8000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0},
    '{2'b10, 10'h3F0, 32'h0,        16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}
  };
  string VR [NV] = '{"R2 tagged store", "R2 tagged load", "R1 R4 data load alias",
    "R6 load strip", "R3 partial store", "R3 tag cleared", "R7 store denied",
    "R7 nothing written", "R8 untagged store", "R8 untagged result", "R5 misaligned store",
    "R5 misaligned load", "R2 last word", "R3 zero mask", "R3 zero mask kept tag",
    "R4 top byte store", "R4 top byte cleared tag"};

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input string rq);
    logic [DW-1:0] wd, ed;
    logic [5:0] w;
    wd = {4{v.seed}};
    w  = v.addr[9:4];
    ed = (v.op[0] || v.ef) ? '0 : mm[w];
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_wdata = wd; req_wmask = v.mask;
    req_wtag = v.wtag; req_pg_ld_cap = v.pgl; req_pg_st_cap = v.pgs;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {rq, " R10 valid"}, DW'(rsp_valid), 1);
    chk(rsp_rdata == ed, {rq, " data"}, rsp_rdata, ed);
    chk(rsp_rtag == v.et, {rq, " tag"}, DW'(rsp_rtag), DW'(v.et));
    chk(rsp_fault == v.ef && rsp_fcode == v.ec, {rq, " fault"}, DW'({rsp_fault, rsp_fcode}), DW'({v.ef, v.ec}));
    chk(rsp_faddr == (v.ef ? v.addr : 10'h0), {rq, " R10 faddr"}, DW'(rsp_faddr), DW'(v.ef ? v.addr : 10'h0));
    if (!v.ef && v.op == 2'b11) begin mm[w] = wd; mt[w] = v.wtag; end
    if (v.op == 2'b01) begin
      for (int b = 0; b < BY; b++) if (v.mask[b]) mm[w][b*8 +: 8] = wd[b*8 +: 8];
      if (|v.mask) mt[w] = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mm[i] = '0;
    mt = '0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 rsp_valid low in reset", DW'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready", DW'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9 idle after reset", DW'(rsp_valid), 0);
    for (int i = 0; i < NV; i++) run(V[i], VR[i]);
    // directed: reset clears tags and data
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NW; i++) mm[i] = '0;
    mt = '0;
    run('{2'b10, 10'h040, 32'h0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, "R9 word 4 after reset");
    run('{2'b10, 10'h3F0, 32'h0, 16'h0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0}, "R9 last word after reset");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 valid drops", DW'(rsp_valid), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule